// File: doc/BRIEF.md
# Branch Target Buffer Fetch Predictor with Decode Recovery

This block chooses the next fetch address for an in-order pipeline. In the fetch stage it looks up the current PC in a small direct-mapped buffer. A hit whose stored last outcome was taken sends fetch to the stored target. Every other case falls through to PC + 4. The lookup result and the sequential PC are registered, so they move into decode together with the instruction.

In decode, the surrounding pipeline supplies four things for the instruction it holds: a branch flag, the register operand, the compare operation and the immediate. The block resolves the real direction of the branch and computes the taken target. When the real direction disagrees with the prediction, it raises a one-cycle redirect carrying the correct PC. In the same cycle it trains the buffer. A branch that missed is allocated with its tag, target and outcome. A branch that hit has only its outcome bit rewritten. A redirect wins over the fetch-stage prediction when the next fetch address is chosen.

Top module: `fetchBtbPredictor`

## Requirements
- R1: After reset, every entry is invalid, so any fetch address gives nextFetchPc = fetchPc + 4 until a branch has been trained.
- R2: A lookup misses when the indexed entry (index fetchPc[5:2]) is invalid or holds a different tag (fetchPc[31:6]). On a miss, nextFetchPc = fetchPc + 4.
- R3: A hit whose stored outcome bit is not-taken gives nextFetchPc = fetchPc + 4.
- R4: A hit whose stored outcome bit is taken gives nextFetchPc = the stored target.
- R5: The actual direction uses the compare code as follows: 0 = taken when operand == 0; 1 = taken when operand != 0; 2 = taken when the operand is negative (two's complement); 3 = taken when the operand is >= 0.
- R6: The taken target is the decoded instruction's PC + 4 plus the sign-extended 16-bit immediate (a byte offset).
- R7: If a branch was predicted taken and resolves not-taken, redirectValid is high and redirectPc = branch PC + 4.
- R8: If a branch was predicted not-taken and resolves taken, redirectValid is high and redirectPc = the taken target.
- R9: If a branch resolves in the predicted direction, redirectValid stays low.
- R10: A resolved branch that missed at fetch is allocated whatever its direction: valid set, tag, taken target and outcome written. A later fetch of that PC predicts from the new entry.
- R11: A resolved branch that hit at fetch has its outcome bit rewritten with the actual direction. Its stored target is left unchanged.
- R12: When decIsBranch is low, there is no redirect and no buffer update.
- R13: While redirectValid is high, nextFetchPc equals redirectPc.
- R14: A fetch lookup in the same cycle as a write to the same entry sees the entry's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | 32 | PC of the instruction in fetch |
| decIsBranch | input | 1 | Instruction in decode is a conditional branch |
| decOpA | input | 32 | Register operand compared against zero |
| decCmpOp | input | 2 | Compare code of the branch in decode |
| decImm | input | 16 | Branch offset immediate in bytes |
| nextFetchPc | output | 32 | PC to fetch in the next cycle |
| redirectValid | output | 1 | Decode detected a misprediction this cycle |
| redirectPc | output | 32 | Corrected fetch PC when redirectValid is high |

## Verification
The hardest case to reach from the ports is a write and a read of the same entry in the same cycle, where the write does not also raise a redirect. A redirect would override nextFetchPc and hide the read. The stimulus reaches this case in three steps. First it fetches an address that aliases a trained taken branch. It then resolves that alias as a not-taken miss, which allocates without a redirect. In the same cycle it fetches the original branch, which must still predict the old target, and one cycle later it must miss. Keeping a stored target unchanged on a hit is also checked: a hit branch is resolved with a different immediate, and the next prediction must still use the original target.

// File: rtl/btbPkg.sv
package btbPkg;

  typedef enum logic [1:0] {
    CMP_EQZ = 2'd0,
    CMP_NEZ = 2'd1,
    CMP_LTZ = 2'd2,
    CMP_GEZ = 2'd3
  } cmpOpE;

  // strobes from the resolve control to the datapath
  typedef struct packed {
    logic fullWrite;     // allocate entry: valid, tag, target, outcome
    logic outcomeWrite;  // rewrite only the outcome bit
    logic outcomeBit;    // resolved direction
    logic redirect;      // misprediction detected
    logic redirectTaken; // redirect goes to the taken target
  } btbCtrlS;

endpackage

// File: rtl/btbTable.sv
module btbTable #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int TAG_W   = PC_W - IDX_W - 2,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [TAG_W-1:0] rdTag,
  output logic             rdHit,
  output logic             rdTaken,
  output logic [PC_W-1:0]  rdTarget,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrFull,
  input  logic             wrOutcome,
  input  logic [TAG_W-1:0] wrTag,
  input  logic [PC_W-1:0]  wrTarget,
  input  logic             wrBit
);

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] outQ;
  logic [TAG_W-1:0]   tagQ    [ENTRIES];
  logic [PC_W-1:0]    targetQ [ENTRIES];
  logic [ENTRIES-1:0] wrSel;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
    assign wrSel[e] = (wrIdx == IDX_W'(e));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wrSel[e] && wrFull) validQ[e] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (wrSel[e] && (wrFull || wrOutcome)) outQ[e] <= wrBit;
      if (wrSel[e] && wrFull) begin
        tagQ[e]    <= wrTag;
        targetQ[e] <= wrTarget;
      end
    end
  end

  // read before write: the registered arrays give the old contents
  always_comb begin
    rdHit    = validQ[rdIdx] && (tagQ[rdIdx] == rdTag);
    rdTaken  = rdHit && outQ[rdIdx];
    rdTarget = targetQ[rdIdx];
  end

endmodule

// File: rtl/btbControl.sv
module btbControl
  import btbPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              decIsBranch,
  input  logic [DATA_W-1:0] decOpA,
  input  logic [1:0]        decCmpOp,
  input  logic              decPredHit,
  input  logic              decPredTaken,
  output btbCtrlS           ctrl
);

  logic actualTaken;

  always_comb begin
    unique case (cmpOpE'(decCmpOp))
      CMP_EQZ: actualTaken = (decOpA == '0);
      CMP_NEZ: actualTaken = (decOpA != '0);
      CMP_LTZ: actualTaken = decOpA[DATA_W-1];
      CMP_GEZ: actualTaken = !decOpA[DATA_W-1];
      default: actualTaken = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.fullWrite     = decIsBranch && !decPredHit;
    ctrl.outcomeWrite  = decIsBranch && decPredHit;
    ctrl.outcomeBit    = actualTaken;
    ctrl.redirect      = decIsBranch && (actualTaken != decPredTaken);
    ctrl.redirectTaken = actualTaken;
  end

endmodule

// File: rtl/btbDatapath.sv
module btbDatapath
  import btbPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int IMM_W = 16,
  localparam int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [IMM_W-1:0] decImm,
  input  btbCtrlS          ctrl,
  output logic             decPredHit,
  output logic             decPredTaken,
  output logic [PC_W-1:0]  nextFetchPc,
  output logic             redirectValid,
  output logic [PC_W-1:0]  redirectPc
);

  localparam logic [PC_W-1:0] INSTR_BYTES = PC_W'(4);

  logic [PC_W-1:0]   fetchSeqPc;
  logic              lookHit;
  logic              lookTaken;
  logic [PC_W-1:0]   lookTarget;
  logic [PC_W-3:0]   decPcQ;
  logic [PC_W-1:0]   decSeqPcQ;
  logic              decHitQ;
  logic              decTakenQ;
  logic [PC_W-1:0]   takenTarget;
  logic [PC_W-1:0]   predPc;
  logic [1:0]        unusedLowBits;

  assign unusedLowBits = fetchPc[1:0];
  assign fetchSeqPc    = fetchPc + INSTR_BYTES;

  btbTable #(.PC_W(PC_W), .IDX_W(IDX_W)) i_table (
    .clk       (clk),
    .rstN      (rstN),
    .rdIdx     (fetchPc[IDX_W+1:2]),
    .rdTag     (fetchPc[PC_W-1:IDX_W+2]),
    .rdHit     (lookHit),
    .rdTaken   (lookTaken),
    .rdTarget  (lookTarget),
    .wrIdx     (decPcQ[IDX_W-1:0]),
    .wrFull    (ctrl.fullWrite),
    .wrOutcome (ctrl.outcomeWrite),
    .wrTag     (decPcQ[PC_W-3:IDX_W]),
    .wrTarget  (takenTarget),
    .wrBit     (ctrl.outcomeBit)
  );

  // prediction travels with the instruction into decode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decPcQ    <= '0;
      decSeqPcQ <= '0;
      decHitQ   <= 1'b0;
      decTakenQ <= 1'b0;
    end else begin
      decPcQ    <= fetchPc[PC_W-1:2];
      decSeqPcQ <= fetchSeqPc;
      decHitQ   <= lookHit;
      decTakenQ <= lookTaken;
    end
  end

  assign decPredHit   = decHitQ;
  assign decPredTaken = decTakenQ;

  assign takenTarget = decSeqPcQ + {{(PC_W-IMM_W){decImm[IMM_W-1]}}, decImm};

  always_comb begin
    predPc        = lookTaken ? lookTarget : fetchSeqPc;
    redirectValid = ctrl.redirect;
    redirectPc    = ctrl.redirectTaken ? takenTarget : decSeqPcQ;
    nextFetchPc   = ctrl.redirect ? redirectPc : predPc;
  end

endmodule

// File: rtl/fetchBtbPredictor.sv
module fetchBtbPredictor
  import btbPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic              decIsBranch,
  input  logic [DATA_W-1:0] decOpA,
  input  logic [1:0]        decCmpOp,
  input  logic [IMM_W-1:0]  decImm,
  output logic [PC_W-1:0]   nextFetchPc,
  output logic              redirectValid,
  output logic [PC_W-1:0]   redirectPc
);

  btbCtrlS ctrl;
  logic    decPredHit;
  logic    decPredTaken;

  btbControl #(.DATA_W(DATA_W)) i_control (
    .decIsBranch  (decIsBranch),
    .decOpA       (decOpA),
    .decCmpOp     (decCmpOp),
    .decPredHit   (decPredHit),
    .decPredTaken (decPredTaken),
    .ctrl         (ctrl)
  );

  btbDatapath #(.PC_W(PC_W), .IDX_W(IDX_W), .IMM_W(IMM_W)) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .fetchPc       (fetchPc),
    .decImm        (decImm),
    .ctrl          (ctrl),
    .decPredHit    (decPredHit),
    .decPredTaken  (decPredTaken),
    .nextFetchPc   (nextFetchPc),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc)
  );

endmodule

// File: rtl/btbChecker.sv
module btbChecker #(
  parameter int PC_W   = 32,
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   fetchPc,
  input logic              decIsBranch,
  input logic [DATA_W-1:0] decOpA,
  input logic [1:0]        decCmpOp,
  input logic [IMM_W-1:0]  decImm,
  input logic [PC_W-1:0]   nextFetchPc,
  input logic              redirectValid,
  input logic [PC_W-1:0]   redirectPc
);

  logic armQ;
  logic chkTaken;
  logic [PC_W-1:0] immExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armQ <= 1'b0;
    else       armQ <= 1'b1;
  end

  always_comb begin
    case (decCmpOp)
      2'd0:    chkTaken = ~|decOpA;
      2'd1:    chkTaken = |decOpA;
      2'd2:    chkTaken = decOpA[DATA_W-1];
      default: chkTaken = ~decOpA[DATA_W-1];
    endcase
    immExt = PC_W'($signed(decImm));
  end

  // R12
  no_branch_no_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decIsBranch |-> !redirectValid);

  // R13
  redirect_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> nextFetchPc == redirectPc);

  // R7
  fallthrough_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    armQ && redirectValid && !chkTaken |-> redirectPc == $past(fetchPc) + PC_W'(4));

  // R8
  taken_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    armQ && redirectValid && chkTaken |-> redirectPc == $past(fetchPc) + PC_W'(4) + immExt);

endmodule

bind fetchBtbPredictor btbChecker #(.PC_W(PC_W), .IMM_W(IMM_W), .DATA_W(DATA_W)) i_btbChecker (
  .clk           (clk),
  .rstN          (rstN),
  .fetchPc       (fetchPc),
  .decIsBranch   (decIsBranch),
  .decOpA        (decOpA),
  .decCmpOp      (decCmpOp),
  .decImm        (decImm),
  .nextFetchPc   (nextFetchPc),
  .redirectValid (redirectValid),
  .redirectPc    (redirectPc)
);

// File: tb/test_fetchBtbPredictor.sv
module test_fetchBtbPredictor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        decIsBranch = 1'b0;
  logic [31:0] decOpA = '0;
  logic [1:0]  decCmpOp = '0;
  logic [15:0] decImm = '0;
  logic [31:0] nextFetchPc;
  logic        redirectValid;
  logic [31:0] redirectPc;

  always #10 clk = ~clk; // 50 MHz

  fetchBtbPredictor i_fetchBtbPredictor (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .decIsBranch(decIsBranch),
    .decOpA(decOpA), .decCmpOp(decCmpOp), .decImm(decImm),
    .nextFetchPc(nextFetchPc), .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  typedef struct {
    logic [31:0] expNext;
    logic        expRedir;
    logic [31:0] expRpc;
    string       tag;
  } expItemS;

  expItemS expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // requirement model of the buffer
  bit          mValid [16];
  logic [25:0] mTag   [16];
  logic [31:0] mTarget[16];
  bit          mOut   [16];
  logic [31:0] pPc = '0;
  bit          pHit = 1'b0;
  bit          pTaken = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] fpc, input bit isBr, input logic [31:0] a,
                      input logic [1:0] op, input logic [15:0] imm, input string tag);
    expItemS it;
    int idx;
    int didx;
    bit hit;
    bit taken;
    bit act;
    logic [31:0] seq;
    logic [31:0] tgt;
    @(negedge clk);
    fetchPc = fpc; decIsBranch = isBr; decOpA = a; decCmpOp = op; decImm = imm;
    idx   = int'(fpc[5:2]);
    hit   = mValid[idx] && (mTag[idx] == fpc[31:6]);
    taken = hit && mOut[idx];
    case (op)
      2'd0: act = (a == 0);
      2'd1: act = (a != 0);
      2'd2: act = a[31];
      default: act = !a[31];
    endcase
    seq = pPc + 32'd4;
    tgt = seq + {{16{imm[15]}}, imm};
    it.tag      = tag;
    it.expRedir = isBr && (act != pTaken);
    it.expRpc   = act ? tgt : seq;
    it.expNext  = it.expRedir ? it.expRpc : (taken ? mTarget[idx] : fpc + 32'd4);
    #2;
    expQ.push_back(it);
    if (isBr) begin
      didx = int'(pPc[5:2]);
      if (!pHit) begin
        mValid[didx] = 1'b1; mTag[didx] = pPc[31:6]; mTarget[didx] = tgt;
      end
      mOut[didx] = act;
    end
    pPc = fpc; pHit = hit; pTaken = taken;
  endtask

  // monitor
  initial begin
    expItemS it;
    forever begin
      wait (expQ.size() > 0);
      it = expQ.pop_front();
      chk(nextFetchPc == it.expNext, it.tag, "nextFetchPc", nextFetchPc, it.expNext);
      chk(redirectValid == it.expRedir, it.tag, "redirectValid",
          {31'd0, redirectValid}, {31'd0, it.expRedir});
      if (it.expRedir)
        chk(redirectPc == it.expRpc, it.tag, "redirectPc", redirectPc, it.expRpc);
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: every index invalid after reset
    for (int i = 0; i < 16; i++) step(32'h1000 + 32'(i * 4), 0, 0, 0, 0, "R1");
    step(32'h40, 0, 0, 0, 0, "R2");
    // R8: miss predicted not-taken, resolves taken
    step(32'h44, 1, 0, 2'd0, 16'h0020, "R8");
    step(32'h64, 0, 0, 0, 0, "R10");
    // R4 / R10: allocated taken entry
    step(32'h40, 0, 0, 0, 0, "R4");
    // R7: predicted taken, resolves not-taken
    step(32'h64, 1, 0, 2'd1, 16'h0020, "R7");
    step(32'h44, 0, 0, 0, 0, "R11");
    // R3: hit with outcome not-taken
    step(32'h40, 0, 0, 0, 0, "R3");
    // R11: hit resolves taken with a different offset
    step(32'h44, 1, 5, 2'd1, 16'h0100, "R11");
    step(32'h40, 0, 0, 0, 0, "R11");
    // R9: correctly predicted taken
    step(32'h44, 1, 32'hFFFF_FFFF, 2'd2, 16'h0020, "R9");
    // R2: aliasing tag misses
    step(32'h80, 0, 0, 0, 0, "R2");
    // R14: not-taken allocation of 0x80 while 0x40 is read
    step(32'h40, 1, 0, 2'd1, 16'h0008, "R14");
    step(32'h40, 0, 0, 0, 0, "R10");
    step(32'h80, 0, 0, 0, 0, "R10");
    // R6: negative offset
    step(32'h308, 0, 0, 0, 0, "R6");
    step(32'h30C, 1, 32'h8000_0000, 2'd2, 16'hFFF0, "R6");
    step(32'h2FC, 0, 0, 0, 0, "R13");
    // R12: non-branch with a would-be taken compare
    step(32'h700, 0, 0, 0, 0, "R12");
    step(32'h704, 0, 0, 2'd0, 16'h0040, "R12");
    step(32'h700, 0, 0, 0, 0, "R12");
    // R5: each compare code on zero, positive and negative operands
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] a;
        a = (k == 0) ? 32'd0 : (k == 1) ? 32'd5 : 32'hFFFF_FFFD;
        step(32'h600 + 32'(op * 64 + k * 8), 0, 0, 0, 0, "R5");
        step(32'h604 + 32'(op * 64 + k * 8), 1, a, 2'(op), 16'h0010, "R5");
      end
    end
    step(32'h900, 0, 0, 0, 0, "R13");
    @(negedge clk);
    wait (expQ.size() == 0);
    #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule